// File: doc/BRIEF.md
# Strobe-Driven Fall-Through FIFO with Fill Flags

This block is a first-in first-out buffer of 64 words, each 9 bits wide. A producer and a consumer exchange words by pulsing strobes instead of using a clocked valid/ready handshake. The rising edge and the falling edge of each strobe are separate events. On the write strobe, the rising edge captures the input word and the falling edge commits it to storage. On the read strobe, the rising edge claims the word at the head and the falling edge retires it and presents the next one. Both strobes are brought into the system clock domain through synchronizer chains before their edges are detected. Each strobe must therefore stay high, and stay low, for at least two clocks.

When the buffer is empty, a committed word falls through to the data output at once, with no read needed. Two ready flags tell each side when it may pulse its strobe. Two fill flags, read together, report one of four fill levels. The output enable drives a data-valid indication and forces the modelled output bus to zero when the bus is released.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `dout` is 0, `in_rdy` is 1, `out_rdy` is 0 and {`stat_mid`,`stat_top`} is 00. Reset also returns both pointers to the first slot.
- R2: A write-strobe high phase that is accepted drives `in_rdy` low. When the buffer holds 64 words, a write strobe is ignored: `in_rdy` stays low and the word never comes out of the buffer.
- R3: After the falling edge of a write strobe into an empty buffer, that word appears on `dout` and `out_rdy` goes high, with no read strobe.
- R4: The rising edge of a read strobe drives `out_rdy` low. After its falling edge, `dout` shows the next word in write order. Each strobe edge takes effect at the ports within 4 clocks.
- R5: When the final word is retired, `out_rdy` stays low and `dout` keeps that word. A read strobe given while `out_rdy` is low has no effect, and the next written word still falls through.
- R6: The fill code {`stat_mid`,`stat_top`} means: 00 empty, 10 between 1 and 32 words, 11 more than 32 words, 01 all 64 words. Filling with no reads, the code becomes 10 on the first write's falling edge, 11 on the 33rd write's rising edge, and 01 on the 64th write's rising edge.
- R7: From the full state, `in_rdy` stays low and the code stays 01 during the first read strobe's high phase. After that strobe's falling edge, the code is 11 and `in_rdy` is 1. `stat_top` clears on the rising edge of the read strobe that brings the count from 33 to 32.
- R8: With `oe_n` high, `dout_drive` is 0 and `dout` is 0. With `oe_n` low, `dout_drive` is 1 and `dout` shows the head word.
- R9: A write strobe and a read strobe pulsed together are both served. The count is unchanged and write order is kept, including when only one word is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| wr_strobe | input | 1 | Write strobe, two-edge event |
| rd_strobe | input | 1 | Read strobe, two-edge event |
| din | input | 9 | Word to write, held stable while `wr_strobe` is high |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 9 | Head word, or 0 while released |
| dout_drive | output | 1 | High while the output bus is driven |
| in_rdy | output | 1 | A write may be pulsed |
| out_rdy | output | 1 | A word is available to read |
| stat_mid | output | 1 | Fill flag, upper bit of the fill code |
| stat_top | output | 1 | Fill flag, lower bit of the fill code |

## Verification
A wrong occupancy count shows up on the fill code within four clocks of a strobe edge. Around the 32-word and 64-word boundaries, such an error gives a code that does not match the number of accepted writes minus retired reads. A read or write pointer that slips shows up on `dout` at the next read falling edge: words come out of order, repeated or missing against the scoreboard. A stuck reservation bit leaves `in_rdy` or `out_rdy` low after a strobe's falling edge, so the next ready check catches it.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Fill code {mid, top} from the committed count and the pending
  // reservations of each side.
  function automatic logic [1:0] fill_code(input int unsigned held,
                                           input logic        wr_pend,
                                           input logic        rd_pend,
                                           input int unsigned depth);
    int unsigned claimed;
    int unsigned net;
    logic        mid;
    logic        top;
    claimed = held + int'(wr_pend);
    net     = claimed - int'(rd_pend);
    mid     = (held != 0) && (claimed < depth);
    top     = net > (depth / 2);
    return {mid, top};
  endfunction

  // Next committed count after write and read commits.
  function automatic int unsigned next_held(input int unsigned held,
                                            input logic        wr_done,
                                            input logic        rd_done);
    return held + int'(wr_done) - int'(rd_done);
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;

  generate
    genvar g;
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its past
  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/fifo_track.sv
module fifo_track
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic          rd_rise,
  input  logic          rd_fall,
  output logic          wr_take,
  output logic          wr_commit,
  output logic          rd_commit,
  output logic          live_nx,
  output logic          in_rdy,
  output logic          out_rdy,
  output logic          stat_mid,
  output logic          stat_top
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_nx;
  logic          wr_busy_q;
  logic          rd_busy_q;
  logic          rd_take;
  logic [1:0]    code;

  assign wr_take   = wr_rise && !wr_busy_q && (count_q != FULLV);
  assign wr_commit = wr_fall && wr_busy_q;
  assign rd_take   = rd_rise && !rd_busy_q && (count_q != '0);
  assign rd_commit = rd_fall && rd_busy_q;

  assign count_nx = CW'(next_held(int'(count_q), wr_commit, rd_commit));
  assign live_nx  = count_nx != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      wr_busy_q <= 1'b0;
      rd_busy_q <= 1'b0;
    end else begin
      count_q <= count_nx;
      if (wr_take)        wr_busy_q <= 1'b1;
      else if (wr_commit) wr_busy_q <= 1'b0;
      if (rd_take)        rd_busy_q <= 1'b1;
      else if (rd_commit) rd_busy_q <= 1'b0;
    end
  end

  assign code     = fill_code(int'(count_q), wr_busy_q, rd_busy_q, DEPTH);
  assign stat_mid = code[1];
  assign stat_top = code[0];
  assign in_rdy   = !wr_busy_q && (count_q != FULLV);
  assign out_rdy  = !rd_busy_q && (count_q != '0);

  assert_full_rejects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !wr_busy_q && count_q == FULLV) |=> !wr_busy_q);

  assert_read_claims_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && out_rdy) |=> !out_rdy);

  assert_empty_read_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && count_q == '0) |=> !rd_busy_q);

  assert_empty_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !wr_busy_q) |-> (!stat_mid && !stat_top));

  assert_full_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == FULLV) |-> (!stat_mid && stat_top));

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_take,
  input  logic              wr_commit,
  input  logic              rd_commit,
  input  logic              live_nx,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] head_q;
  logic [DATA_W-1:0] head_src;
  logic [AW-1:0]     wptr_q;
  logic [AW-1:0]     rptr_q;
  logic [AW-1:0]     rptr_nx;

  assign rptr_nx  = rptr_q + AW'(rd_commit);
  // the word being committed is the new head when it lands on the read slot
  assign head_src = (wr_commit && rptr_nx == wptr_q) ? hold_q : mem[rptr_nx];

  always_ff @(posedge clk) begin
    if (wr_commit) mem[wptr_q] <= hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      head_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_take)   hold_q <= din;
      if (wr_commit) wptr_q <= wptr_q + AW'(1);
      rptr_q <= rptr_nx;
      if (live_nx)   head_q <= head_src;
    end
  end

  assign head = head_q;

  assert_rptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_commit |=> (rptr_q == $past(rptr_q) + AW'(1)));

  assert_wptr_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(wptr_q));

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DATA_W      = 9,
  parameter int unsigned DEPTH       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drive,
  output logic              in_rdy,
  output logic              out_rdy,
  output logic              stat_mid,
  output logic              stat_top
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic              wr_rise, wr_fall, rd_rise, rd_fall;
  logic              wr_take, wr_commit, rd_commit, live_nx;
  logic [DATA_W-1:0] head;

  strobe_edge #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .pin(wr_strobe), .rise(wr_rise), .fall(wr_fall));

  strobe_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .pin(rd_strobe), .rise(rd_rise), .fall(rd_fall));

  fifo_track #(.DEPTH(DEPTH), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .wr_rise(wr_rise), .wr_fall(wr_fall), .rd_rise(rd_rise), .rd_fall(rd_fall),
    .wr_take(wr_take), .wr_commit(wr_commit), .rd_commit(rd_commit),
    .live_nx(live_nx), .in_rdy(in_rdy), .out_rdy(out_rdy),
    .stat_mid(stat_mid), .stat_top(stat_top));

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .din(din),
    .wr_take(wr_take), .wr_commit(wr_commit), .rd_commit(rd_commit),
    .live_nx(live_nx), .head(head));

  assign dout_drive = ~oe_n;
  assign dout       = oe_n ? '0 : head;

  assert_ready_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && rd_commit) |=> out_rdy);

endmodule

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_strobe = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [8:0] din = '0;
  logic       oe_n = 1'b0;
  logic [8:0] dout;
  logic       dout_drive, in_rdy, out_rdy, stat_mid, stat_top;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  logic [8:0] sb[$];
  logic [8:0] last_out = '0;

  always #4 clk = ~clk;

  strobe_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
    .din(din), .oe_n(oe_n), .dout(dout), .dout_drive(dout_drive),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .stat_mid(stat_mid), .stat_top(stat_top));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // expected fill code from the word count: n held, plus side reservations
  function automatic int want_code(input int n, input bit wpend, input bit rpend);
    bit mid;
    bit top;
    if (n == 0) mid = 0;
    else if (wpend && n == 63) mid = 0;
    else if (n == 64) mid = 0;
    else mid = 1;
    top = (n + int'(wpend) - int'(rpend)) >= 33;
    return {mid, top};
  endfunction

  // driver: pulse a write, push the word when accepted
  task automatic put(input logic [8:0] d, input string req);
    int n;
    bit ok;
    n  = sb.size();
    ok = n < 64;
    din = d;
    wr_strobe = 1'b1;
    settle();
    chk({req, " in_rdy high phase"}, in_rdy, 0);
    chk({req, " code high phase"}, {stat_mid, stat_top}, want_code(n, ok, 0));
    wr_strobe = 1'b0;
    settle();
    if (ok) sb.push_back(d);
    chk({req, " in_rdy after"}, in_rdy, sb.size() < 64);
    chk({req, " code after"}, {stat_mid, stat_top}, want_code(sb.size(), 0, 0));
    if (n == 0 && ok) begin
      chk({req, " fall-through R3"}, dout, d);
      chk({req, " out_rdy R3"}, out_rdy, 1);
      last_out = d;
    end
  endtask

  // monitor side: pulse a read, pop and compare
  task automatic take(input string req);
    int n;
    n = sb.size();
    rd_strobe = 1'b1;
    settle();
    chk({req, " out_rdy high phase"}, out_rdy, 0);
    if (n > 0)
      chk({req, " code high phase"}, {stat_mid, stat_top}, want_code(n, 0, 1));
    rd_strobe = 1'b0;
    settle();
    if (n > 0) void'(sb.pop_front());
    if (sb.size() > 0) begin
      chk({req, " next word R4"}, dout, sb[0]);
      chk({req, " out_rdy after R4"}, out_rdy, 1);
      last_out = sb[0];
    end else begin
      chk({req, " held word R5"}, dout, last_out);
      chk({req, " out_rdy empty R5"}, out_rdy, 0);
    end
    chk({req, " code after"}, {stat_mid, stat_top}, want_code(sb.size(), 0, 0));
  endtask

  task automatic both(input logic [8:0] d, input string req);
    int n;
    n = sb.size();
    din = d;
    wr_strobe = 1'b1;
    rd_strobe = 1'b1;
    settle();
    wr_strobe = 1'b0;
    rd_strobe = 1'b0;
    settle();
    void'(sb.pop_front());
    sb.push_back(d);
    chk({req, " count kept R9"}, {stat_mid, stat_top}, want_code(n, 0, 0));
    chk({req, " head R9"}, dout, sb[0]);
    chk({req, " out_rdy R9"}, out_rdy, 1);
    last_out = sb[0];
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dout in reset", dout, 0);
    chk("R1 in_rdy in reset", in_rdy, 1);
    chk("R1 out_rdy in reset", out_rdy, 0);
    chk("R1 code in reset", {stat_mid, stat_top}, 0);
    rst_n = 1'b1;
    settle();
    chk("R1 code after release", {stat_mid, stat_top}, 0);
    chk("R1 out_rdy after release", out_rdy, 0);

    // R3 fall-through, R4 ordered reads, R5 drain
    put(9'h1A5, "R2 R3 first");
    put(9'h033, "R2 second");
    put(9'h100, "R2 third");
    take("R4 read1");
    take("R4 read2");
    take("R5 read last");
    take("R5 read on empty");
    chk("R5 dout unchanged", dout, 9'h100);
    put(9'h0C7, "R5 refill");

    // R8 output enable
    oe_n = 1'b1;
    @(negedge clk);
    chk("R8 drive off", dout_drive, 0);
    chk("R8 dout released", dout, 0);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R8 drive on", dout_drive, 1);
    chk("R8 dout restored", dout, 9'h0C7);

    // R9 simultaneous with one word held, then with several
    both(9'h055, "R9 single");
    put(9'h0AA, "R9 prep");
    both(9'h1FF, "R9 multi");
    take("R9 drain1");
    take("R9 drain2");

    // R6 fill to the top, R2 reject, R7 unload
    for (int i = 0; i < 64; i++) put(9'((i * 37 + 5) & 9'h1FF), "R6 fill");
    chk("R6 full code", {stat_mid, stat_top}, 2'b01);
    put(9'h0EE, "R2 write while full");
    chk("R2 still 64", {stat_mid, stat_top}, 2'b01);
    take("R7 first read from full");
    chk("R7 in_rdy back", in_rdy, 1);
    while (sb.size() > 0) take("R7 unload");
    chk("R2 rejected word absent, empty code", {stat_mid, stat_top}, 0);

    finish_run();
  end
endmodule